// File: doc/BRIEF.md
# Three-Wire Serial Register Access Port

This block gives an external bus master access to a small on-chip byte register file through three wires: a serial clock, an active-low select and one data line. Because the data line is shared, the block brings it out as separate input, output and output-enable signals, and a pad joins them. Every transaction opens with a 16-bit command word. The top bit of that word chooses read or write. A two-bit code sets how many data bytes follow. The low thirteen bits give the start address. The data bytes follow as 8-bit words. On a write the block stores each byte. On a read the block turns the line around and shifts the register contents out.

The serial pins are sampled on the system clock, and rising edges of the serial clock are found by comparing the pin with its value one cycle earlier. Byte 0 of the register file is the port setup byte. Its bit 0 selects whether the command word and the data bytes travel least-significant bit first. After a command, the address moves one step per data byte. It counts down when the frame runs most-significant bit first and counts up when it runs least-significant bit first. A counted transfer may pause with the select raised between data bytes. A streaming transfer runs until the select rises.

Top module: `spi3w_regport`

## Requirements
- R1: After reset, sdioOe is 0, every register reads 0x00, and frames use most-significant-bit-first order.
- R2: sdioIn is sampled on each rising edge of sclk while csN is low. The first 16 bits form the command word: bit 15 is read (1) or write (0), bits 14:13 are the length code, and bits 12:0 are the start address. sdioOe stays 0 during these 16 bits.
- R3: In a write frame, each complete data byte is stored at the current address on its eighth rising edge.
- R4: In a read frame, sdioOe goes to 1 after the 16th rising edge. Each data bit is on sdioOut before the rising edge that consumes it, so the master samples it on that edge.
- R5: Length codes 0, 1 and 2 move 1, 2 and 3 bytes. After the last byte, further sclk edges store nothing and sdioOe returns to 0 until the frame ends.
- R6: Length code 3 streams bytes without limit until csN rises.
- R7: After each data byte the address moves by one, with 13-bit wraparound. It moves down in most-significant-bit-first frames and up in least-significant-bit-first frames.
- R8: Bit 0 of register 0, when set, makes both the command word and the data travel least-significant bit first. A change to it takes effect from the next frame.
- R9: In a counted frame, csN may go high at a boundary between data bytes. The frame then resumes at the next byte with the same address and byte count once csN returns low.
- R10: If csN rises during the command word, in the middle of a byte, after the last byte, or during streaming, the frame ends without storing a partial byte. The next low csN starts a new command word.
- R11: Writes to addresses at or above the register depth are dropped, and reads from them return 0x00.
- R12: sdioOe is 0 whenever csN is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rstN | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock from the master |
| csN | input | 1 | Active-low frame select |
| sdioIn | input | 1 | Value seen on the shared data line |
| sdioOut | output | 1 | Value driven onto the data line during reads |
| sdioOe | output | 1 | Output enable for the shared data line |

## Verification
Two events can fall in the same system cycle: the eighth rising edge of a data byte, which stores the byte and steps the address, and a rise of csN. The bench raises csN right after byte boundaries, both to stall counted frames and to end streaming ones. In those frames the address must survive a stall exactly, and a streamed frame must end without writing stray bytes. Readback after the frame shows both. Random frames mix stalls and extra bytes, and include writes to the setup byte that flip the bit order. Every read is compared with a reference array that models the stepping direction and the one-frame delay before a new bit order takes effect.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_INSTR,
    PH_DATA,
    PH_STALL,
    PH_DONE
  } phase_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clear;       // drop instruction state and shift contents
    logic sample;      // take one bit from the data line
    logic loadInstr;   // command word complete
    logic writeByte;   // store assembled byte at current address
    logic stepAddr;    // move address after a data byte
    logic trackOrder;  // follow the bit-order setting between frames
  } strobe_t;

  localparam int BYTE_BITS = 8;

endpackage

// File: rtl/spi3w_ctrl.sv
module spi3w_ctrl
  import spi3w_pkg::*;
#(
  parameter int INSTR_BITS = 16,
  parameter int CNT_W      = $clog2(INSTR_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclk,
  input  logic             csN,
  input  logic             instrRead,
  input  logic [1:0]       instrLen,
  output strobe_t          stb,
  output logic [CNT_W-1:0] bitCnt,
  output phase_t           phase,
  output logic             sdioOe
);

  localparam logic [CNT_W-1:0] LAST_INSTR = CNT_W'(INSTR_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_DATA  = CNT_W'(BYTE_BITS - 1);

  logic             sclkQ;
  logic             rise;
  logic             stream;
  logic [1:0]       byteCnt;
  phase_t           phaseNxt;
  logic [CNT_W-1:0] bitNxt;
  logic [1:0]       byteNxt;

  assign rise   = sclk & ~sclkQ;
  assign stream = (instrLen == 2'b11);

  always_comb begin
    stb      = '0;
    phaseNxt = phase;
    bitNxt   = bitCnt;
    byteNxt  = byteCnt;
    if (csN) begin
      if (phase == PH_STALL || (phase == PH_DATA && bitCnt == '0 && !stream)) begin
        phaseNxt = PH_STALL;
      end else begin
        phaseNxt  = PH_IDLE;
        bitNxt    = '0;
        byteNxt   = '0;
        stb.clear = 1'b1;
      end
    end else begin
      unique case (phase)
        PH_IDLE: begin
          phaseNxt = PH_INSTR;
          bitNxt   = '0;
          byteNxt  = '0;
        end
        PH_STALL: phaseNxt = PH_DATA;
        PH_INSTR: if (rise) begin
          stb.sample = 1'b1;
          if (bitCnt == LAST_INSTR) begin
            stb.loadInstr = 1'b1;
            phaseNxt      = PH_DATA;
            bitNxt        = '0;
          end else begin
            bitNxt = bitCnt + 1'b1;
          end
        end
        PH_DATA: if (rise) begin
          stb.sample = 1'b1;
          if (bitCnt == LAST_DATA) begin
            bitNxt        = '0;
            stb.writeByte = !instrRead;
            stb.stepAddr  = 1'b1;
            if (!stream) begin
              byteNxt = byteCnt + 1'b1;
              if (byteCnt == instrLen) phaseNxt = PH_DONE;
            end
          end else begin
            bitNxt = bitCnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
    stb.trackOrder = (phase == PH_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ   <= 1'b0;
      phase   <= PH_IDLE;
      bitCnt  <= '0;
      byteCnt <= '0;
    end else begin
      sclkQ   <= sclk;
      phase   <= phaseNxt;
      bitCnt  <= bitNxt;
      byteCnt <= byteNxt;
    end
  end

  assign sdioOe = !csN && instrRead && (phase == PH_DATA);

endmodule

// File: rtl/spi3w_dp.sv
module spi3w_dp
  import spi3w_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DEPTH     = 16,
  parameter int CFG_ADDR  = 0,
  parameter int ORDER_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              sdioIn,
  input  logic [2:0]        bitIdx,
  output logic              instrRead,
  output logic [1:0]        instrLen,
  output logic [ADDR_W-1:0] addr,
  output logic              frameLsb,
  output logic              sdioOut
);

  localparam int INSTR_BITS = ADDR_W + 3;
  localparam int IDX_W      = $clog2(DEPTH);

  logic [INSTR_BITS-1:0] shiftReg;
  logic [INSTR_BITS-1:0] shiftNxt;
  logic [BYTE_BITS-1:0]  newByte;
  logic [BYTE_BITS-1:0]  rdByte;
  logic [BYTE_BITS-1:0]  regs [DEPTH];
  logic                  inRange;
  logic [IDX_W-1:0]      idx;

  assign shiftNxt = frameLsb ? {sdioIn, shiftReg[INSTR_BITS-1:1]}
                             : {shiftReg[INSTR_BITS-2:0], sdioIn};
  assign newByte  = frameLsb ? shiftNxt[INSTR_BITS-1 -: BYTE_BITS]
                             : shiftNxt[BYTE_BITS-1:0];
  assign inRange  = (addr < ADDR_W'(DEPTH));
  assign idx      = addr[IDX_W-1:0];
  assign rdByte   = inRange ? regs[idx] : '0;
  assign sdioOut  = frameLsb ? rdByte[bitIdx] : rdByte[3'd7 - bitIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      instrRead <= 1'b0;
      instrLen  <= '0;
      addr      <= '0;
      frameLsb  <= 1'b0;
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else begin
      if (stb.clear) begin
        shiftReg  <= '0;
        instrRead <= 1'b0;
        instrLen  <= '0;
        addr      <= '0;
      end else begin
        if (stb.sample) shiftReg <= shiftNxt;
        if (stb.loadInstr) begin
          instrRead <= shiftNxt[INSTR_BITS-1];
          instrLen  <= shiftNxt[INSTR_BITS-2 -: 2];
          addr      <= shiftNxt[ADDR_W-1:0];
        end
        if (stb.stepAddr) addr <= frameLsb ? addr + 1'b1 : addr - 1'b1;
        if (stb.writeByte && inRange) regs[idx] <= newByte;
      end
      if (stb.trackOrder) frameLsb <= regs[CFG_ADDR][ORDER_BIT];
    end
  end

endmodule

// File: rtl/spi3w_regport.sv
module spi3w_regport
  import spi3w_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DEPTH     = 16,
  parameter int CFG_ADDR  = 0,
  parameter int ORDER_BIT = 0
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclk,
  input  logic csN,
  input  logic sdioIn,
  output logic sdioOut,
  output logic sdioOe
);

  localparam int INSTR_BITS = ADDR_W + 3;
  localparam int CNT_W      = $clog2(INSTR_BITS);

  strobe_t           stb;
  phase_t            phase;
  logic [CNT_W-1:0]  bitCnt;
  logic              instrRead;
  logic [1:0]        instrLen;
  logic [ADDR_W-1:0] addr;
  logic              frameLsb;

  spi3w_ctrl #(.INSTR_BITS(INSTR_BITS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN),
    .instrRead(instrRead), .instrLen(instrLen),
    .stb(stb), .bitCnt(bitCnt), .phase(phase), .sdioOe(sdioOe)
  );

  spi3w_dp #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CFG_ADDR(CFG_ADDR), .ORDER_BIT(ORDER_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdioIn(sdioIn), .bitIdx(bitCnt[2:0]),
    .instrRead(instrRead), .instrLen(instrLen), .addr(addr),
    .frameLsb(frameLsb), .sdioOut(sdioOut)
  );

endmodule

// File: rtl/spi3w_regport_chk.sv
module spi3w_regport_chk
  import spi3w_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              sdioOe,
  input strobe_t           stb,
  input phase_t            phase,
  input logic [ADDR_W-1:0] addr,
  input logic              frameLsb
);

  AST_STEP_DIR: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepAddr |=> addr == ($past(frameLsb) ? $past(addr) + 1'b1 : $past(addr) - 1'b1)); // R7

  AST_NO_STORE_IN_READ: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeByte |-> !sdioOe); // R4

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (!stb.sample && !stb.writeByte)); // R10

  AST_ORDER_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(frameLsb)); // R8

  AST_DONE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DONE) |-> (!sdioOe && !stb.writeByte)); // R5

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STALL) |=> $stable(addr)); // R9

endmodule

bind spi3w_regport spi3w_regport_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sdioOe(sdioOe), .stb(stb),
  .phase(phase), .addr(addr), .frameLsb(frameLsb)
);

// File: tb/spi3w_regport_bench.sv
module spi3w_regport_bench;

  logic clk = 1'b0;
  logic rstN, sclk, csN, sdioIn;
  logic sdioOut, sdioOe;

  int errors = 0;
  int checks = 0;

  logic [7:0] refMem [16];
  logic       refLsb;
  logic [7:0] txBuf  [8];

  always #10 clk = ~clk;

  spi3w_regport u_spi3w_regport (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN),
    .sdioIn(sdioIn), .sdioOut(sdioOut), .sdioOe(sdioOe)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] refRead(input logic [12:0] a);
    return (a < 13'd16) ? refMem[a[3:0]] : 8'h00;
  endfunction

  task automatic clockBit(input logic b, output logic got, output logic oe);
    @(negedge clk);
    sdioIn = b;
    sclk   = 1'b0;
    repeat (2) @(negedge clk);
    got  = sdioOut;
    oe   = sdioOe;
    sclk = 1'b1;
    repeat (2) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic runFrame(input logic rw, input logic [1:0] lenCode, input logic [12:0] addr,
                          input int nBytes, input logic stall, input string tag);
    logic [15:0] ins;
    logic        got, oe, oeBad, lsb;
    logic [7:0]  rb, expv;
    logic [12:0] a;
    int          limit;
    ins = {rw, lenCode, addr};
    lsb = refLsb;
    csN = 1'b0;
    repeat (2) @(negedge clk);
    oeBad = 1'b0;
    for (int i = 0; i < 16; i++) begin
      clockBit(lsb ? ins[i] : ins[15-i], got, oe);
      if (oe) oeBad = 1'b1;
    end
    check(!oeBad, "R2", oeBad, 0);
    limit = (lenCode == 2'b11) ? nBytes : int'(lenCode) + 1;
    a = addr;
    for (int k = 0; k < nBytes; k++) begin
      if (stall && k > 0 && lenCode != 2'b11) begin
        csN = 1'b1;
        repeat (3) @(negedge clk);
        check(sdioOe == 1'b0, "R12", sdioOe, 0);
        csN = 1'b0;
        repeat (2) @(negedge clk);
      end
      rb = 8'h00;
      oeBad = 1'b0;
      for (int i = 0; i < 8; i++) begin
        int bi;
        bi = lsb ? i : 7 - i;
        clockBit(txBuf[k][bi], got, oe);
        rb[bi] = got;
        if (oe != (rw && k < limit)) oeBad = 1'b1;
      end
      check(!oeBad, (k < limit) ? "R4" : "R5", oeBad, 0);
      if (k < limit) begin
        if (rw) begin
          expv = refRead(a);
          check(rb == expv, tag, rb, expv);
        end else if (a < 13'd16) begin
          refMem[a[3:0]] = txBuf[k];
        end
        a = lsb ? a + 13'd1 : a - 13'd1;
      end
    end
    csN = 1'b1;
    repeat (3) @(negedge clk);
    check(sdioOe == 1'b0, "R12", sdioOe, 0);
    refLsb = refMem[0][0];
  endtask

  // starts a write to addr, sends nBits bits, then deselects early
  task automatic abortFrame(input logic [12:0] addr, input int nBits);
    logic [15:0] ins;
    logic        got, oe;
    ins = {1'b0, 2'b00, addr};
    csN = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nBits; i++) begin
      if (i < 16) clockBit(refLsb ? ins[i] : ins[15-i], got, oe);
      else        clockBit(1'b1, got, oe);
    end
    csN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'h5eed);
    for (int i = 0; i < 16; i++) refMem[i] = 8'h00;
    refLsb = 1'b0;
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; sdioIn = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state
    check(sdioOe == 1'b0, "R1", sdioOe, 0);
    runFrame(1'b1, 2'b00, 13'd5, 1, 1'b0, "R1");

    // R3: single write and readback
    txBuf[0] = 8'hA5;
    runFrame(1'b0, 2'b00, 13'd3, 1, 1'b0, "R3");
    runFrame(1'b1, 2'b00, 13'd3, 1, 1'b0, "R3");

    // R7: two bytes, address counts down in msb-first order
    txBuf[0] = 8'h3C; txBuf[1] = 8'hC3;
    runFrame(1'b0, 2'b01, 13'd7, 2, 1'b0, "R7");
    runFrame(1'b1, 2'b01, 13'd7, 2, 1'b0, "R7");

    // R5: extra bytes after the counted one are ignored
    txBuf[0] = 8'h11; txBuf[1] = 8'h22; txBuf[2] = 8'h33;
    runFrame(1'b0, 2'b00, 13'd10, 3, 1'b0, "R5");
    runFrame(1'b1, 2'b10, 13'd10, 3, 1'b0, "R5");

    // R9: stalls between bytes keep the position
    txBuf[0] = 8'h5A; txBuf[1] = 8'h6B; txBuf[2] = 8'h7C;
    runFrame(1'b0, 2'b10, 13'd12, 3, 1'b1, "R9");
    runFrame(1'b1, 2'b10, 13'd12, 3, 1'b1, "R9");

    // R6: streaming
    for (int i = 0; i < 6; i++) txBuf[i] = 8'(8'h90 + i * 7);
    runFrame(1'b0, 2'b11, 13'd14, 6, 1'b0, "R6");
    runFrame(1'b1, 2'b11, 13'd15, 7, 1'b0, "R6");

    // R11: out of range address
    txBuf[0] = 8'hEE;
    runFrame(1'b0, 2'b00, 13'd40, 1, 1'b0, "R11");
    runFrame(1'b1, 2'b00, 13'd40, 1, 1'b0, "R11");
    runFrame(1'b1, 2'b00, 13'd8, 1, 1'b0, "R11");

    // R7: wrap from address 0 down to the top of the space
    runFrame(1'b1, 2'b01, 13'd0, 2, 1'b0, "R7");

    // R10: aborted frames store nothing, next frame starts clean
    abortFrame(13'd3, 20);
    runFrame(1'b1, 2'b00, 13'd3, 1, 1'b0, "R10");
    abortFrame(13'd3, 7);
    txBuf[0] = 8'h4D;
    runFrame(1'b0, 2'b00, 13'd2, 1, 1'b0, "R10");
    runFrame(1'b1, 2'b00, 13'd2, 1, 1'b0, "R10");

    // R8: switch to lsb-first, address counts up
    txBuf[0] = 8'h01;
    runFrame(1'b0, 2'b00, 13'd0, 1, 1'b0, "R8");
    txBuf[0] = 8'h81; txBuf[1] = 8'h42;
    runFrame(1'b0, 2'b01, 13'd4, 2, 1'b0, "R8");
    runFrame(1'b1, 2'b01, 13'd4, 2, 1'b1, "R8");
    // R8: order change written mid-frame applies only from next frame
    txBuf[0] = 8'hB2; txBuf[1] = 8'h00; txBuf[2] = 8'h5C;
    runFrame(1'b0, 2'b10, 13'd15, 3, 1'b0, "R8");
    runFrame(1'b1, 2'b10, 13'd1, 3, 1'b0, "R8");

    // random frames, R3 for reads
    for (int n = 0; n < 40; n++) begin
      logic        rw, st;
      logic [1:0]  len;
      logic [12:0] ad;
      int          nb;
      rw  = 1'($urandom % 2);
      len = 2'($urandom % 4);
      ad  = 13'($urandom % 20);
      nb  = (len == 2'b11) ? 1 + int'($urandom % 5) : int'(len) + 1 + int'($urandom % 2);
      st  = 1'($urandom % 2);
      for (int i = 0; i < 8; i++) txBuf[i] = 8'($urandom);
      runFrame(rw, len, ad, nb, st, "R3");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule